// File: doc/BRIEF.md
# Super I/O Resource Address Decoder

This block turns the configuration bytes of an integrated legacy-peripheral controller into live I/O resources for four devices: a floppy controller, a parallel port and two serial ports. From a function-enable byte, a power-down byte, per-device base-address bytes and three routing bytes, it works out each device's base address and whether its window is active. It then compares the incoming I/O address against every active window and drives one chip select per device.

The parallel port has an address window of 4 or 8 bytes, chosen by a two-bit mode field, and a base address that must land inside a legal range before the window opens. The block also passes through each device's interrupt and DMA channel numbers, the parallel-port protocol flags and a floppy drive-swap flag. It keeps none of the configuration itself: the register storage and the peripherals sit elsewhere. All outputs are registered.

Top module: `sio_res_decoder`

## Requirements
- R1: The floppy base is `(fdc_base_reg & 0xFC) << 2` (10 bits). The floppy window is active only when `fn_en[4]` is 1 and `pwr_dis[1:0]` is 00. The window covers 8 addresses starting at the base.
- R2: When `fn_en[1:0]` equals 2, `lpt_wide` is 1 and the parallel window covers 8 addresses. For any other value it covers 4 addresses and `lpt_wide` is 0.
- R3: The parallel base is `lpt_base_reg << 2`, masked with 0x3F8 in 8-byte mode and with 0x3FC in 4-byte mode. The window is active only when this base is at least 0x100 and at most 0x3F8 (8-byte) or 0x3FC (4-byte).
- R4: The parallel window is inactive when `fn_en[1:0]` equals 3, when `pwr_dis[0]` is 1 or when `pwr_dis[4]` is 1.
- R5: The protocol flags come from `lpt_mode_reg`. With bits 1:0 = 1, `lpt_ecp` is 1 and `lpt_epp` equals bit 5. With bits 1:0 = 2, `lpt_epp` is 1 and `lpt_ecp` equals bit 5. With bits 1:0 = 0 or 3, both flags are 0. `lpt_ext` always equals bit 7.
- R6: Serial port n (0 or 1) has base `ser_base_reg[n] << 2` and an 8-address window. It is active when `fn_en[2+n]` is 1 and both `pwr_dis[2+n]` and `pwr_dis[0]` are 0. `ser_base` packs port 0 in bits 9:0 and port 1 in bits 19:10.
- R7: DMA and IRQ routing:
  - `fdc_dma` = `dma_route[1:0]` and `lpt_dma` = `dma_route[3:2]`.
  - `fdc_irq` = `irq_route_a[3:0]` and `lpt_irq` = `irq_route_a[7:4]`.
  - `ser_irq[3:0]` = `irq_route_b[3:0]` (port 0) and `ser_irq[7:4]` = `irq_route_b[7:4]` (port 1).
- R8: `lpt_irq_con` is 1 exactly when the parallel IRQ number is nonzero. A zero IRQ number means the parallel interrupt is disconnected.
- R9: `fdc_swap` equals `fdc_misc_reg[0]`. The other bits of that byte have no effect on any output.
- R10: A chip select is raised only for an address whose bits above bit 9 are zero and which falls inside an active window. At most one chip select is high at a time. Where windows overlap, the priority is floppy, then parallel, then serial 0, then serial 1. `ser_cs` bit n belongs to port n.
- R11: Every output updates on the first clock edge after its inputs change. While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_en | input | 8 | Function-enable byte (parallel mode, serial and floppy enables) |
| fdc_base_reg | input | 8 | Floppy base-address byte |
| lpt_base_reg | input | 8 | Parallel base-address byte |
| ser_base_reg | input | 16 | Serial base-address bytes, port 1 in bits 15:8 |
| pwr_dis | input | 8 | Power-down / disable byte |
| lpt_mode_reg | input | 8 | Parallel protocol-mode byte |
| fdc_misc_reg | input | 8 | Floppy miscellaneous byte (bit 0 = drive swap) |
| dma_route | input | 8 | DMA routing byte |
| irq_route_a | input | 8 | Floppy and parallel IRQ routing byte |
| irq_route_b | input | 8 | Serial IRQ routing byte |
| io_addr | input | 16 | Incoming I/O address |
| fdc_base | output | 10 | Floppy base address |
| fdc_en | output | 1 | Floppy window active |
| fdc_cs | output | 1 | Floppy chip select |
| fdc_irq | output | 4 | Floppy IRQ number |
| fdc_dma | output | 2 | Floppy DMA channel |
| fdc_swap | output | 1 | Floppy drive swap |
| lpt_base | output | 10 | Parallel base address |
| lpt_en | output | 1 | Parallel window active |
| lpt_wide | output | 1 | Parallel window is 8 bytes |
| lpt_cs | output | 1 | Parallel chip select |
| lpt_irq | output | 4 | Parallel IRQ number |
| lpt_irq_con | output | 1 | Parallel interrupt connected |
| lpt_dma | output | 2 | Parallel DMA channel |
| lpt_ecp | output | 1 | Extended-capability protocol on |
| lpt_epp | output | 1 | Enhanced protocol on |
| lpt_ext | output | 1 | Extended flag |
| ser_base | output | 20 | Serial base addresses |
| ser_en | output | 2 | Serial windows active |
| ser_cs | output | 2 | Serial chip selects |
| ser_irq | output | 8 | Serial IRQ numbers |

## Verification
The properties assume that configuration inputs hold steady for at least one edge once reset is released. Outputs are compared with the previous cycle's inputs only after an arm flag has seen one clean edge out of reset. The bench follows this rule: it changes inputs only on the falling edge and samples one full cycle later, so each registered result reflects one settled input set. The window properties assume no particular address pattern, so the bench is free to probe window edges, overlapping windows and addresses with nonzero upper bits.

// File: rtl/sio_dec_pkg.sv
package sio_dec_pkg;
    parameter int REG_W   = 8;
    parameter int BASE_W  = 10;
    parameter int IRQ_W   = 4;
    parameter int DMA_W   = 2;
    parameter int NUM_SER = 2;
    parameter int NUM_DEV = 2 + NUM_SER;

    // legal parallel base range
    parameter logic [BASE_W-1:0] LPT_MIN      = 10'h100;
    parameter logic [BASE_W-1:0] LPT_MAX_NARW = 10'h3FC;
    parameter logic [BASE_W-1:0] LPT_MAX_WIDE = 10'h3F8;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              en;
    } win_t;

    typedef struct packed {
        logic ecp;
        logic epp;
        logic ext;
    } lpt_flags_t;

    typedef struct packed {
        win_t                     fdc;
        logic [IRQ_W-1:0]         fdc_irq;
        logic [DMA_W-1:0]         fdc_dma;
        logic                     fdc_swap;
        win_t                     lpt;
        logic                     lpt_wide;
        lpt_flags_t               lpt_flags;
        logic [IRQ_W-1:0]         lpt_irq;
        logic                     lpt_irq_con;
        logic [DMA_W-1:0]         lpt_dma;
        win_t [NUM_SER-1:0]       ser;
        logic [NUM_SER*IRQ_W-1:0] ser_irq;
        logic [NUM_DEV-1:0]       cs;
    } dec_state_t;
endpackage

// File: rtl/sio_fdc_win.sv
module sio_fdc_win
    import sio_dec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [REG_W-1:0]  fn_en,
    input  logic [REG_W-1:0]  pwr_dis,
    input  logic [REG_W-1:0]  base_reg,
    input  logic [ADDR_W-1:0] io_addr,
    output win_t              win,
    output logic              hit
);
    localparam int SPAN_LOG2 = 3;

    logic upper_zero;

    always_comb begin
        win.base   = {base_reg[REG_W-1:2], 2'b00, 2'b00};
        win.en     = fn_en[4] && (pwr_dis[1:0] == 2'b00);
        upper_zero = (io_addr[ADDR_W-1:BASE_W] == '0);
        hit        = win.en && upper_zero &&
                     (io_addr[BASE_W-1:SPAN_LOG2] == win.base[BASE_W-1:SPAN_LOG2]);
    end
endmodule

// File: rtl/sio_lpt_win.sv
module sio_lpt_win
    import sio_dec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [REG_W-1:0]  fn_en,
    input  logic [REG_W-1:0]  pwr_dis,
    input  logic [REG_W-1:0]  base_reg,
    input  logic [REG_W-1:0]  mode_reg,
    input  logic [ADDR_W-1:0] io_addr,
    output win_t              win,
    output logic              wide,
    output lpt_flags_t        flags,
    output logic              hit
);
    localparam logic [1:0] MODE_WIDE = 2'd2;
    localparam logic [1:0] MODE_OFF  = 2'd3;
    localparam logic [1:0] PROT_ECP  = 2'd1;
    localparam logic [1:0] PROT_EPP  = 2'd2;

    logic [BASE_W-1:0] raw_base;
    logic [BASE_W-1:0] max_base;
    logic              in_range;
    logic              upper_zero;
    logic              low_match;

    always_comb begin
        wide     = (fn_en[1:0] == MODE_WIDE);
        raw_base = {base_reg, 2'b00};
        if (wide) begin
            win.base = {raw_base[BASE_W-1:3], 3'b000};
            max_base = LPT_MAX_WIDE;
        end else begin
            win.base = raw_base;
            max_base = LPT_MAX_NARW;
        end
        in_range = (win.base >= LPT_MIN) && (win.base <= max_base);
        win.en   = in_range && (fn_en[1:0] != MODE_OFF) &&
                   !pwr_dis[0] && !pwr_dis[4];

        upper_zero = (io_addr[ADDR_W-1:BASE_W] == '0);
        if (wide)
            low_match = (io_addr[BASE_W-1:3] == win.base[BASE_W-1:3]);
        else
            low_match = (io_addr[BASE_W-1:2] == win.base[BASE_W-1:2]);
        hit = win.en && upper_zero && low_match;

        flags.ext = mode_reg[7];
        unique case (mode_reg[1:0])
            PROT_ECP: begin
                flags.ecp = 1'b1;
                flags.epp = mode_reg[5];
            end
            PROT_EPP: begin
                flags.epp = 1'b1;
                flags.ecp = mode_reg[5];
            end
            default: begin
                flags.ecp = 1'b0;
                flags.epp = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sio_uart_win.sv
module sio_uart_win
    import sio_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PORT   = 0
) (
    input  logic [REG_W-1:0]  fn_en,
    input  logic [REG_W-1:0]  pwr_dis,
    input  logic [REG_W-1:0]  base_reg,
    input  logic [ADDR_W-1:0] io_addr,
    output win_t              win,
    output logic              hit
);
    localparam int SPAN_LOG2 = 3;
    localparam int EN_BIT    = 2 + PORT;

    always_comb begin
        win.base = {base_reg, 2'b00};
        win.en   = fn_en[EN_BIT] && !pwr_dis[EN_BIT] && !pwr_dis[0];
        hit      = win.en && (io_addr[ADDR_W-1:BASE_W] == '0) &&
                   (io_addr[BASE_W-1:SPAN_LOG2] == win.base[BASE_W-1:SPAN_LOG2]);
    end
endmodule

// File: rtl/sio_cs_prio.sv
module sio_cs_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] hit,   // bit N-1 has the highest priority
    output logic [N-1:0] cs
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        cs    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i] && !taken) begin
                cs[i] = 1'b1;
                taken = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sio_res_decoder.sv
module sio_res_decoder
    import sio_dec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [REG_W-1:0]           fn_en,
    input  logic [REG_W-1:0]           fdc_base_reg,
    input  logic [REG_W-1:0]           lpt_base_reg,
    input  logic [NUM_SER*REG_W-1:0]   ser_base_reg,
    input  logic [REG_W-1:0]           pwr_dis,
    input  logic [REG_W-1:0]           lpt_mode_reg,
    input  logic [REG_W-1:0]           fdc_misc_reg,
    input  logic [REG_W-1:0]           dma_route,
    input  logic [REG_W-1:0]           irq_route_a,
    input  logic [REG_W-1:0]           irq_route_b,
    input  logic [ADDR_W-1:0]          io_addr,
    output logic [BASE_W-1:0]          fdc_base,
    output logic                       fdc_en,
    output logic                       fdc_cs,
    output logic [IRQ_W-1:0]           fdc_irq,
    output logic [DMA_W-1:0]           fdc_dma,
    output logic                       fdc_swap,
    output logic [BASE_W-1:0]          lpt_base,
    output logic                       lpt_en,
    output logic                       lpt_wide,
    output logic                       lpt_cs,
    output logic [IRQ_W-1:0]           lpt_irq,
    output logic                       lpt_irq_con,
    output logic [DMA_W-1:0]           lpt_dma,
    output logic                       lpt_ecp,
    output logic                       lpt_epp,
    output logic                       lpt_ext,
    output logic [NUM_SER*BASE_W-1:0]  ser_base,
    output logic [NUM_SER-1:0]         ser_en,
    output logic [NUM_SER-1:0]         ser_cs,
    output logic [NUM_SER*IRQ_W-1:0]   ser_irq
);
    // chip-select vector order, highest priority in the top bit
    localparam int IDX_FDC = NUM_DEV - 1;
    localparam int IDX_LPT = NUM_DEV - 2;

    win_t               fdc_win;
    win_t               lpt_win;
    win_t [NUM_SER-1:0] ser_win;
    logic               fdc_hit;
    logic               lpt_hit;
    logic [NUM_SER-1:0] ser_hit;
    logic               lpt_wide_w;
    lpt_flags_t         lpt_flags_w;
    logic [NUM_DEV-1:0] hit_vec;
    logic [NUM_DEV-1:0] cs_vec;

    dec_state_t st_d;
    dec_state_t st_q;

    sio_fdc_win #(.ADDR_W(ADDR_W)) i_fdc_win (
        .fn_en    (fn_en),
        .pwr_dis  (pwr_dis),
        .base_reg (fdc_base_reg),
        .io_addr  (io_addr),
        .win      (fdc_win),
        .hit      (fdc_hit)
    );

    sio_lpt_win #(.ADDR_W(ADDR_W)) i_lpt_win (
        .fn_en    (fn_en),
        .pwr_dis  (pwr_dis),
        .base_reg (lpt_base_reg),
        .mode_reg (lpt_mode_reg),
        .io_addr  (io_addr),
        .win      (lpt_win),
        .wide     (lpt_wide_w),
        .flags    (lpt_flags_w),
        .hit      (lpt_hit)
    );

    for (genvar n = 0; n < NUM_SER; n++) begin : g_ser
        sio_uart_win #(.ADDR_W(ADDR_W), .PORT(n)) i_uart_win (
            .fn_en    (fn_en),
            .pwr_dis  (pwr_dis),
            .base_reg (ser_base_reg[n*REG_W +: REG_W]),
            .io_addr  (io_addr),
            .win      (ser_win[n]),
            .hit      (ser_hit[n])
        );
        // serial 0 ranks above serial 1
        assign hit_vec[NUM_SER-1-n] = ser_hit[n];
    end

    assign hit_vec[IDX_FDC] = fdc_hit;
    assign hit_vec[IDX_LPT] = lpt_hit;

    sio_cs_prio #(.N(NUM_DEV)) i_cs_prio (
        .hit (hit_vec),
        .cs  (cs_vec)
    );

    always_comb begin
        st_d             = '0;
        st_d.fdc         = fdc_win;
        st_d.fdc_irq     = irq_route_a[IRQ_W-1:0];
        st_d.fdc_dma     = dma_route[DMA_W-1:0];
        st_d.fdc_swap    = fdc_misc_reg[0];
        st_d.lpt         = lpt_win;
        st_d.lpt_wide    = lpt_wide_w;
        st_d.lpt_flags   = lpt_flags_w;
        st_d.lpt_irq     = irq_route_a[REG_W-1 -: IRQ_W];
        st_d.lpt_irq_con = (irq_route_a[REG_W-1 -: IRQ_W] != '0);
        st_d.lpt_dma     = dma_route[2*DMA_W-1 -: DMA_W];
        st_d.ser         = ser_win;
        for (int n = 0; n < NUM_SER; n++)
            st_d.ser_irq[n*IRQ_W +: IRQ_W] = irq_route_b[n*IRQ_W +: IRQ_W];
        st_d.cs          = cs_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        fdc_base    = st_q.fdc.base;
        fdc_en      = st_q.fdc.en;
        fdc_cs      = st_q.cs[IDX_FDC];
        fdc_irq     = st_q.fdc_irq;
        fdc_dma     = st_q.fdc_dma;
        fdc_swap    = st_q.fdc_swap;
        lpt_base    = st_q.lpt.base;
        lpt_en      = st_q.lpt.en;
        lpt_wide    = st_q.lpt_wide;
        lpt_cs      = st_q.cs[IDX_LPT];
        lpt_irq     = st_q.lpt_irq;
        lpt_irq_con = st_q.lpt_irq_con;
        lpt_dma     = st_q.lpt_dma;
        lpt_ecp     = st_q.lpt_flags.ecp;
        lpt_epp     = st_q.lpt_flags.epp;
        lpt_ext     = st_q.lpt_flags.ext;
        ser_irq     = st_q.ser_irq;
        for (int n = 0; n < NUM_SER; n++) begin
            ser_base[n*BASE_W +: BASE_W] = st_q.ser[n].base;
            ser_en[n]                    = st_q.ser[n].en;
            ser_cs[n]                    = st_q.cs[NUM_SER-1-n];
        end
    end
endmodule

// File: rtl/sio_dec_chk.sv
module sio_dec_chk
    import sio_dec_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic [REG_W-1:0]          fn_en,
    input logic [REG_W-1:0]          pwr_dis,
    input logic [REG_W-1:0]          dma_route,
    input logic [REG_W-1:0]          irq_route_a,
    input logic [REG_W-1:0]          fdc_misc_reg,
    input logic                      fdc_en,
    input logic                      fdc_cs,
    input logic [DMA_W-1:0]          fdc_dma,
    input logic                      fdc_swap,
    input logic [BASE_W-1:0]         lpt_base,
    input logic                      lpt_en,
    input logic                      lpt_wide,
    input logic                      lpt_cs,
    input logic                      lpt_irq_con,
    input logic [NUM_SER-1:0]        ser_en,
    input logic [NUM_SER-1:0]        ser_cs
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r10_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fdc_cs, lpt_cs, ser_cs}));

    a_r10_cs_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
        (({fdc_cs, lpt_cs, ser_cs} & ~{fdc_en, lpt_en, ser_en}) == '0));

    a_r3_lpt_base_legal: assert property (@(posedge clk) disable iff (!rst_n)
        lpt_en |-> (lpt_base >= LPT_MIN) &&
                   (lpt_base <= (lpt_wide ? LPT_MAX_WIDE : LPT_MAX_NARW)));

    a_r2_lpt_wide_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (lpt_en && lpt_wide) |-> (lpt_base[2:0] == 3'b000));

    a_r4_lpt_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (($past(fn_en[1:0]) == 2'b11) || $past(pwr_dis[0]) || $past(pwr_dis[4])))
        |-> !lpt_en);

    a_r6_ser_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(pwr_dis[0])) |-> (ser_en == '0));

    a_r1_fdc_follows: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (fdc_en == ($past(fn_en[4]) && ($past(pwr_dis[1:0]) == 2'b00))));

    a_r7_fdc_dma_follows: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (fdc_dma == $past(dma_route[1:0])));

    a_r8_irq_connect: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (lpt_irq_con == ($past(irq_route_a[7:4]) != 4'd0)));

    a_r9_swap_follows: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (fdc_swap == $past(fdc_misc_reg[0])));
endmodule

bind sio_res_decoder sio_dec_chk i_sio_dec_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fn_en        (fn_en),
    .pwr_dis      (pwr_dis),
    .dma_route    (dma_route),
    .irq_route_a  (irq_route_a),
    .fdc_misc_reg (fdc_misc_reg),
    .fdc_en       (fdc_en),
    .fdc_cs       (fdc_cs),
    .fdc_dma      (fdc_dma),
    .fdc_swap     (fdc_swap),
    .lpt_base     (lpt_base),
    .lpt_en       (lpt_en),
    .lpt_wide     (lpt_wide),
    .lpt_cs       (lpt_cs),
    .lpt_irq_con  (lpt_irq_con),
    .ser_en       (ser_en),
    .ser_cs       (ser_cs)
);

// File: tb/test_sio_res_decoder.sv
module test_sio_res_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 22;

    // {fn_en, fdc_base_reg, lpt_base_reg, ser0, ser1, pwr_dis, io_addr, en{f,l,s0,s1}, cs{f,l,s0,s1}}
    localparam logic [71:0] VEC [NV] = '{
        {8'h1C, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h00, 16'h03F0, 4'hF, 4'h8},
        {8'h1C, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h00, 16'h03F7, 4'hF, 4'h8},
        {8'h1C, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h00, 16'h03F8, 4'hF, 4'h2},
        {8'h1C, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h00, 16'h037B, 4'hF, 4'h4},
        {8'h1C, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h00, 16'h037C, 4'hF, 4'h0},
        {8'h1C, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h00, 16'h02FF, 4'hF, 4'h1},
        {8'h1E, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h00, 16'h037C, 4'hF, 4'h4},
        {8'h1F, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h00, 16'h0378, 4'hB, 4'h0},
        {8'h1C, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h01, 16'h03F0, 4'h0, 4'h0},
        {8'h1C, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h10, 16'h0378, 4'hB, 4'h0},
        {8'h1C, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h04, 16'h03F8, 4'hD, 4'h0},
        {8'h1C, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h08, 16'h02F8, 4'hE, 4'h0},
        {8'h1C, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h02, 16'h03F0, 4'h7, 4'h0},
        {8'h1C, 8'hFC, 8'h3F, 8'hFE, 8'hBE, 8'h00, 16'h00FC, 4'hB, 4'h0},
        {8'h1C, 8'hFC, 8'h40, 8'hFE, 8'hBE, 8'h00, 16'h0100, 4'hF, 4'h4},
        {8'h1C, 8'hFC, 8'hFC, 8'hFE, 8'hBE, 8'h00, 16'h03F0, 4'hF, 4'h8},
        {8'h1C, 8'hFC, 8'hDE, 8'hFC, 8'hBE, 8'h00, 16'h03F2, 4'hF, 4'h8},
        {8'h1C, 8'hFC, 8'hDE, 8'hBE, 8'hBE, 8'h00, 16'h02F8, 4'hF, 4'h2},
        {8'h1C, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h00, 16'h13F0, 4'hF, 4'h0},
        {8'h00, 8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h00, 16'h0378, 4'h4, 4'h4},
        {8'h1E, 8'hFC, 8'hDF, 8'hFE, 8'hBE, 8'h00, 16'h037F, 4'hF, 4'h4},
        {8'h1C, 8'hFC, 8'hDF, 8'hFE, 8'hBE, 8'h00, 16'h0378, 4'hF, 4'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  fn_en = '0, fdc_base_reg = '0, lpt_base_reg = '0, pwr_dis = '0;
    logic [15:0] ser_base_reg = '0;
    logic [7:0]  lpt_mode_reg = '0, fdc_misc_reg = '0, dma_route = '0;
    logic [7:0]  irq_route_a = '0, irq_route_b = '0;
    logic [15:0] io_addr = '0;

    logic [9:0]  fdc_base, lpt_base;
    logic        fdc_en, fdc_cs, fdc_swap, lpt_en, lpt_wide, lpt_cs, lpt_irq_con;
    logic [3:0]  fdc_irq, lpt_irq;
    logic [1:0]  fdc_dma, lpt_dma, ser_en, ser_cs;
    logic        lpt_ecp, lpt_epp, lpt_ext;
    logic [19:0] ser_base;
    logic [7:0]  ser_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_res_decoder i_sio_res_decoder (
        .clk(clk), .rst_n(rst_n), .fn_en(fn_en), .fdc_base_reg(fdc_base_reg),
        .lpt_base_reg(lpt_base_reg), .ser_base_reg(ser_base_reg), .pwr_dis(pwr_dis),
        .lpt_mode_reg(lpt_mode_reg), .fdc_misc_reg(fdc_misc_reg), .dma_route(dma_route),
        .irq_route_a(irq_route_a), .irq_route_b(irq_route_b), .io_addr(io_addr),
        .fdc_base(fdc_base), .fdc_en(fdc_en), .fdc_cs(fdc_cs), .fdc_irq(fdc_irq),
        .fdc_dma(fdc_dma), .fdc_swap(fdc_swap), .lpt_base(lpt_base), .lpt_en(lpt_en),
        .lpt_wide(lpt_wide), .lpt_cs(lpt_cs), .lpt_irq(lpt_irq), .lpt_irq_con(lpt_irq_con),
        .lpt_dma(lpt_dma), .lpt_ecp(lpt_ecp), .lpt_epp(lpt_epp), .lpt_ext(lpt_ext),
        .ser_base(ser_base), .ser_en(ser_en), .ser_cs(ser_cs), .ser_irq(ser_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // inputs change on the falling edge; results are read one full cycle later
    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        fn_en = 8'h1C; io_addr = 16'h03F0;
        repeat (3) @(negedge clk);
        // R11: reset holds outputs at zero
        check("R11 reset en", {fdc_en, lpt_en, ser_en}, 0);
        check("R11 reset cs", {fdc_cs, lpt_cs, ser_cs}, 0);
        check("R11 reset base", {fdc_base, lpt_base, ser_base}, 0);
        rst_n = 1'b1;
        settle();

        // R1 R2 R3 R4 R6 R10: windows and chip selects
        for (int v = 0; v < NV; v++) begin
            {fn_en, fdc_base_reg, lpt_base_reg, ser_base_reg[7:0], ser_base_reg[15:8],
             pwr_dis, io_addr} = VEC[v][71:8];
            settle();
            check($sformatf("R1 R4 R6 window enables vec %0d", v),
                  {fdc_en, lpt_en, ser_en[0], ser_en[1]}, VEC[v][7:4]);
            check($sformatf("R10 chip selects vec %0d", v),
                  {fdc_cs, lpt_cs, ser_cs[0], ser_cs[1]}, VEC[v][3:0]);
        end

        // R1: base ignores low two bits of the byte
        fn_en = 8'h1C; pwr_dis = 8'h00; fdc_base_reg = 8'hFF;
        settle();
        check("R1 fdc base", fdc_base, 10'h3F0);

        // R2 R3: wide mode masks bit 2 of the base
        fn_en = 8'h1E; lpt_base_reg = 8'hDF;
        settle();
        check("R2 lpt wide", lpt_wide, 1);
        check("R3 lpt base wide", lpt_base, 10'h378);
        fn_en = 8'h1C;
        settle();
        check("R2 lpt narrow", lpt_wide, 0);
        check("R3 lpt base narrow", lpt_base, 10'h37C);
        lpt_base_reg = 8'hFF;
        settle();
        check("R3 lpt top base legal", {lpt_en, lpt_base}, {1'b1, 10'h3FC});

        // R6: serial base packing
        ser_base_reg = 16'hBEFE;
        settle();
        check("R6 ser bases", ser_base, {10'h2F8, 10'h3F8});

        // R5: protocol flags
        lpt_mode_reg = 8'h01; settle();
        check("R5 mode1", {lpt_ecp, lpt_epp, lpt_ext}, 3'b100);
        lpt_mode_reg = 8'h21; settle();
        check("R5 mode1 b5", {lpt_ecp, lpt_epp, lpt_ext}, 3'b110);
        lpt_mode_reg = 8'h02; settle();
        check("R5 mode2", {lpt_ecp, lpt_epp, lpt_ext}, 3'b010);
        lpt_mode_reg = 8'h22; settle();
        check("R5 mode2 b5", {lpt_ecp, lpt_epp, lpt_ext}, 3'b110);
        lpt_mode_reg = 8'h23; settle();
        check("R5 mode3", {lpt_ecp, lpt_epp, lpt_ext}, 3'b000);
        lpt_mode_reg = 8'h80; settle();
        check("R5 ext", {lpt_ecp, lpt_epp, lpt_ext}, 3'b001);

        // R7 R8: routing
        dma_route = 8'h0E; irq_route_a = 8'h76; irq_route_b = 8'h43;
        settle();
        check("R7 dma", {fdc_dma, lpt_dma}, 4'b10_11);
        check("R7 irq a", {fdc_irq, lpt_irq}, 8'h67);
        check("R7 ser irq", ser_irq, 8'h43);
        check("R8 irq connected", lpt_irq_con, 1);
        irq_route_a = 8'h06; settle();
        check("R8 irq disconnected", {lpt_irq, lpt_irq_con}, 5'b0000_0);

        // R9: swap bit only
        fdc_misc_reg = 8'h01; settle();
        check("R9 swap on", fdc_swap, 1);
        fdc_misc_reg = 8'hFE; settle();
        check("R9 swap off other bits", fdc_swap, 0);

        // R11: one-cycle latency
        fn_en = 8'h1C; pwr_dis = 8'h00; io_addr = 16'h03F0;
        settle();
        pwr_dis = 8'h02;
        #(CLK_PERIOD/4);
        check("R11 before edge", fdc_en, 1);
        settle();
        check("R11 after edge", {fdc_en, fdc_cs}, 2'b00);

        // R11: asynchronous reset clears outputs
        pwr_dis = 8'h00; settle();
        rst_n = 1'b0; #1;
        check("R11 reset clears", {fdc_en, fdc_cs, fdc_base}, 0);
        settle();
        rst_n = 1'b1;
        settle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule